// File: doc/BRIEF.md
# DMA Bus Cycle Sequencer

This block drives the system bus while a DMA controller owns it. Each granted transfer arrives as a one-cycle `start` pulse carrying a 16-bit memory address, a transfer kind and two end-of-block flags. The sequencer puts the low address byte on dedicated address pins. It places the high address byte on the shared 8-bit data bus and pulses an address strobe, so an external latch can capture that byte. It holds an address-enable output high so the latched byte reaches the system address bus. It then drives one memory strobe and the opposite I/O strobe together, so data moves directly between a peripheral and memory without passing through the controller.

The high-byte phase costs one cycle, so it is issued only when needed. That is on the first transfer after reset or after a return to bus-master mode, and whenever the high byte differs from the one last latched. Every transfer then passes through a strobe state, a wait state that stretches while `ready` is low, and a release state. The end-of-block flags are shown in the release state. In slave mode the sequencer drives nothing on the bus. Instead, four of the low address pins and the two I/O strobe pins become inputs that the host uses to select and access internal registers.

Top module: `dma_bus_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `busy`, `done`, `adstb`, `aen`, `data_oe`, `tc_o` and `mark_o` are 0, and `memr_n`, `memw_n`, `ior_n_o` and `iow_n_o` are 1.
- R2: A transfer that needs the high byte starts with exactly one cycle in which `adstb`=1, `data_oe`=1 and `data_o` = address bits 15..8, with all four strobes high. The first transfer after reset needs the high byte.
- R3: A transfer whose high byte equals the one last latched (with no exit from master mode since) skips the high-byte cycle. Its first cycle already carries the strobes, with `adstb`=0 and `data_oe`=0.
- R4: Through every cycle of a transfer, `aen`=1, `addr_lo_oe`=1 and `addr_lo_o` = address bits 7..0.
- R5: Kind 2'b10 (read from memory) drives `memr_n`=0 and `iow_n_o`=0 in the strobe and wait states, with `memw_n`=1 and `ior_n_o`=1.
- R6: Kind 2'b01 (write to memory) drives `ior_n_o`=0 and `memw_n`=0 in the strobe and wait states, with `memr_n`=1 and `iow_n_o`=1.
- R7: Kinds 2'b00 (verify) and 2'b11 run the same states and address timing but keep all four strobes high.
- R8: The wait state lasts at least one cycle and repeats while `ready` is sampled low. The strobes stay asserted throughout.
- R9: The release state lasts one cycle. In it all strobes are high, `done`=1, and `tc_o` and `mark_o` show the flags captured at `start`. In the next cycle `busy`, `done`, `tc_o` and `mark_o` are 0.
- R10: With `master`=0, `addr_lo_oe`, `data_oe`, `io_oe` and `aen` are 0 and `start` is ignored. `reg_sel` follows `addr_lo_i`. `reg_rd` = `!cs_n && !ior_n_i` and `reg_wr` = `!cs_n && !iow_n_i`.
- R11: Spending any cycle with `master`=0 forgets the last high byte, so the next transfer repeats the high-byte cycle even when the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master | input | 1 | Controller owns the system bus |
| start | input | 1 | One-cycle pulse: begin a granted transfer |
| xfer_addr | input | 16 | Memory address of the transfer |
| xfer_kind | input | 2 | 00 verify, 01 write to memory, 10 read from memory, 11 verify |
| xfer_tc | input | 1 | Transfer is the last of the block |
| xfer_mark | input | 1 | Transfer lands on a mark boundary |
| ready | input | 1 | Slow device is ready; ends the wait state |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Release-state pulse |
| addr_lo_o | output | 8 | Low address byte |
| addr_lo_oe | output | 1 | Drive enable for the low address pins |
| addr_lo_i | input | 4 | Low address pins as inputs (slave mode) |
| cs_n | input | 1 | Chip select, active low (slave mode) |
| ior_n_i | input | 1 | I/O read pin as input (slave mode) |
| iow_n_i | input | 1 | I/O write pin as input (slave mode) |
| reg_sel | output | 4 | Internal register select |
| reg_rd | output | 1 | Host register read |
| reg_wr | output | 1 | Host register write |
| data_o | output | 8 | High address byte on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| adstb | output | 1 | High-byte latch strobe |
| aen | output | 1 | Address enable for the external latch |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| io_oe | output | 1 | Drive enable for the I/O strobe pins |
| tc_o | output | 1 | Terminal count indication |
| mark_o | output | 1 | Mark indication |

## Verification
Random transfers draw their high byte from two values and their kind and wait length at random. This mixes transfers that must re-latch the high byte with ones that may skip it, so a missing or spurious high-byte cycle shows up as a one-cycle shift. Kind is varied on every transfer to separate the read pairing, the write pairing and the strobe-free verify. Directed cases cover exit and re-entry to master mode with an unchanged address, long `ready` stalls, and host register access with `start` pulsed while the block is a slave.

// File: rtl/dma_seq_pkg.sv
// Shared types of the DMA bus cycle sequencer.
package dma_seq_pkg;
    typedef enum logic [1:0] {
        XK_VERIFY = 2'b00,
        XK_WRITE  = 2'b01,
        XK_READ   = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_WAIT,
        ST_REL
    } seq_state_e;

    // Active-high internal strobe requests.
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;
endpackage

// File: rtl/seq_fsm.sv
// Transfer state machine. Captures a granted transfer and remembers the last
// latched high address byte, to decide whether a high-byte cycle is needed.
// Assumes start arrives only while idle. Leaving master mode aborts and forgets.
module seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          start,
    input  logic [AW-1:0] xfer_addr,
    input  logic [1:0]    xfer_kind,
    input  logic          xfer_tc,
    input  logic          xfer_mark,
    input  logic          ready,
    output seq_state_e    state,
    output logic [AW-1:0] cur_addr,
    output xfer_kind_e    cur_kind,
    output logic          cur_tc,
    output logic          cur_mark
);
    localparam int HW = AW - LW;

    logic          hi_valid;
    logic [HW-1:0] hi_last;
    logic          need_hi;

    // Decide whether the incoming address needs a high-byte cycle.
    always_comb need_hi = !hi_valid || (xfer_addr[AW-1:LW] != hi_last);

    // State sequencing and capture of the transfer fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            cur_kind <= XK_VERIFY;
            cur_tc   <= 1'b0;
            cur_mark <= 1'b0;
            hi_valid <= 1'b0;
            hi_last  <= '0;
        end else if (!master) begin
            state    <= ST_IDLE;
            hi_valid <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr <= xfer_addr;
                    cur_kind <= xfer_kind_e'(xfer_kind);
                    cur_tc   <= xfer_tc;
                    cur_mark <= xfer_mark;
                    hi_valid <= 1'b1;
                    hi_last  <= xfer_addr[AW-1:LW];
                    state    <= need_hi ? ST_ADDR : ST_STRB;
                end
                ST_ADDR: state <= ST_STRB;
                ST_STRB: state <= ST_WAIT;
                ST_WAIT: if (ready) state <= ST_REL;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_strobe.sv
// Strobe decoder. Pairs a memory strobe with the opposite I/O strobe in the
// strobe and wait states; verify and reserved kinds request nothing.
module seq_strobe
    import dma_seq_pkg::*;
(
    input  seq_state_e state,
    input  xfer_kind_e kind,
    output strobe_t    strb
);
    logic active;

    // Request strobes for the current kind while the strobe window is open.
    always_comb begin
        active      = (state == ST_STRB) || (state == ST_WAIT);
        strb.mem_rd = active && (kind == XK_READ);
        strb.io_wr  = active && (kind == XK_READ);
        strb.io_rd  = active && (kind == XK_WRITE);
        strb.mem_wr = active && (kind == XK_WRITE);
    end
endmodule

// File: rtl/seq_pins.sv
// Pin stage. In master mode it drives address, high byte, latch controls and
// active-low strobes. In slave mode it releases the bus and decodes host access.
module seq_pins
    import dma_seq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LW   = 8,
    parameter int SELW = 4
) (
    input  logic            master,
    input  seq_state_e      state,
    input  logic [AW-1:0]   cur_addr,
    input  strobe_t         strb,
    input  logic            cur_tc,
    input  logic            cur_mark,
    input  logic [SELW-1:0] addr_lo_i,
    input  logic            cs_n,
    input  logic            ior_n_i,
    input  logic            iow_n_i,
    output logic            busy,
    output logic            done,
    output logic [LW-1:0]   addr_lo_o,
    output logic            addr_lo_oe,
    output logic [SELW-1:0] reg_sel,
    output logic            reg_rd,
    output logic            reg_wr,
    output logic [AW-LW-1:0] data_o,
    output logic            data_oe,
    output logic            adstb,
    output logic            aen,
    output logic            memr_n,
    output logic            memw_n,
    output logic            ior_n_o,
    output logic            iow_n_o,
    output logic            io_oe,
    output logic            tc_o,
    output logic            mark_o
);
    logic in_xfer;
    logic in_rel;

    // Master-side bus drive.
    always_comb begin
        in_xfer    = master && (state != ST_IDLE);
        in_rel     = master && (state == ST_REL);
        busy       = in_xfer;
        done       = in_rel;
        aen        = in_xfer;
        addr_lo_oe = in_xfer;
        addr_lo_o  = cur_addr[LW-1:0];
        adstb      = master && (state == ST_ADDR);
        data_oe    = adstb;
        data_o     = cur_addr[AW-1:LW];
        io_oe      = master;
        memr_n     = !(master && strb.mem_rd);
        memw_n     = !(master && strb.mem_wr);
        ior_n_o    = !(master && strb.io_rd);
        iow_n_o    = !(master && strb.io_wr);
        tc_o       = in_rel && cur_tc;
        mark_o     = in_rel && cur_mark;
    end

    // Slave-side host register access decode.
    always_comb begin
        reg_sel = addr_lo_i;
        reg_rd  = !master && !cs_n && !ior_n_i;
        reg_wr  = !master && !cs_n && !iow_n_i;
    end
endmodule

// File: rtl/dma_bus_seq.sv
// Top of the DMA bus cycle sequencer: state machine, strobe decoder, pin stage.
// Assumes the high address width equals the data bus width.
module dma_bus_seq
    import dma_seq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LW   = 8,
    parameter int SELW = 4,
    localparam int HW  = AW - LW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master,
    input  logic            start,
    input  logic [AW-1:0]   xfer_addr,
    input  logic [1:0]      xfer_kind,
    input  logic            xfer_tc,
    input  logic            xfer_mark,
    input  logic            ready,
    output logic            busy,
    output logic            done,
    output logic [LW-1:0]   addr_lo_o,
    output logic            addr_lo_oe,
    input  logic [SELW-1:0] addr_lo_i,
    input  logic            cs_n,
    input  logic            ior_n_i,
    input  logic            iow_n_i,
    output logic [SELW-1:0] reg_sel,
    output logic            reg_rd,
    output logic            reg_wr,
    output logic [HW-1:0]   data_o,
    output logic            data_oe,
    output logic            adstb,
    output logic            aen,
    output logic            memr_n,
    output logic            memw_n,
    output logic            ior_n_o,
    output logic            iow_n_o,
    output logic            io_oe,
    output logic            tc_o,
    output logic            mark_o
);
    seq_state_e    state;
    logic [AW-1:0] cur_addr;
    xfer_kind_e    cur_kind;
    logic          cur_tc;
    logic          cur_mark;
    strobe_t       strb;

    seq_fsm #(.AW(AW), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .master(master), .start(start),
        .xfer_addr(xfer_addr), .xfer_kind(xfer_kind), .xfer_tc(xfer_tc),
        .xfer_mark(xfer_mark), .ready(ready), .state(state),
        .cur_addr(cur_addr), .cur_kind(cur_kind), .cur_tc(cur_tc),
        .cur_mark(cur_mark)
    );

    seq_strobe u_strobe (.state(state), .kind(cur_kind), .strb(strb));

    seq_pins #(.AW(AW), .LW(LW), .SELW(SELW)) u_pins (
        .master(master), .state(state), .cur_addr(cur_addr), .strb(strb),
        .cur_tc(cur_tc), .cur_mark(cur_mark), .addr_lo_i(addr_lo_i),
        .cs_n(cs_n), .ior_n_i(ior_n_i), .iow_n_i(iow_n_i), .busy(busy),
        .done(done), .addr_lo_o(addr_lo_o), .addr_lo_oe(addr_lo_oe),
        .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .data_o(data_o), .data_oe(data_oe), .adstb(adstb), .aen(aen),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n_o(ior_n_o),
        .iow_n_o(iow_n_o), .io_oe(io_oe), .tc_o(tc_o), .mark_o(mark_o)
    );
endmodule

// File: rtl/dma_bus_seq_chk.sv
// Checker for the sequencer's pin-level protocol, bound to the top module.
module dma_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic busy,
    input logic done,
    input logic addr_lo_oe,
    input logic data_oe,
    input logic adstb,
    input logic aen,
    input logic memr_n,
    input logic memw_n,
    input logic ior_n_o,
    input logic iow_n_o,
    input logic io_oe,
    input logic tc_o,
    input logic mark_o
);
    AST_ADSTB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) adstb |=> !adstb); // R2
    AST_ADSTB_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n) adstb |-> (data_oe && aen && memr_n && memw_n && ior_n_o && iow_n_o)); // R2
    AST_STRB_UNDER_AEN: assert property (@(posedge clk) disable iff (!rst_n) (!memr_n || !memw_n) |-> (aen && addr_lo_oe)); // R4
    AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !memr_n |-> (!iow_n_o && memw_n && ior_n_o)); // R5
    AST_WR_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !memw_n |-> (!ior_n_o && memr_n && iow_n_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_FLAGS_IN_REL: assert property (@(posedge clk) disable iff (!rst_n) (tc_o || mark_o) |-> (done && memr_n && memw_n)); // R9
    AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !master |-> (!addr_lo_oe && !data_oe && !io_oe && !aen && !busy)); // R10
endmodule

bind dma_bus_seq dma_bus_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .busy(busy), .done(done),
    .addr_lo_oe(addr_lo_oe), .data_oe(data_oe), .adstb(adstb), .aen(aen),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n_o(ior_n_o), .iow_n_o(iow_n_o),
    .io_oe(io_oe), .tc_o(tc_o), .mark_o(mark_o)
);

// File: tb/tb_dma_bus_seq.sv
// Bench: random transfers with fixed seed plus directed corner cases.
module tb_dma_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n, master, start, xfer_tc, xfer_mark, ready;
    logic [15:0] xfer_addr;
    logic [1:0]  xfer_kind;
    logic [3:0]  addr_lo_i;
    logic        cs_n, ior_n_i, iow_n_i;
    logic        busy, done, addr_lo_oe, reg_rd, reg_wr, data_oe, adstb, aen;
    logic        memr_n, memw_n, ior_n_o, iow_n_o, io_oe, tc_o, mark_o;
    logic [7:0]  addr_lo_o, data_o;
    logic [3:0]  reg_sel;

    int errors = 0;
    int checks = 0;
    bit hv = 0;
    logic [7:0] last_hi = '0;

    always #2 clk = ~clk;

    dma_bus_seq dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_strb(input logic [1:0] k);
        // {memr_n, memw_n, ior_n_o, iow_n_o}
        if (k == 2'b10) return 4'b0110;
        if (k == 2'b01) return 4'b1001;
        return 4'b1111;
    endfunction

    function automatic string kind_req(input logic [1:0] k);
        if (k == 2'b10) return "R5";
        if (k == 2'b01) return "R6";
        return "R7";
    endfunction

    function automatic logic [3:0] pins();
        return {memr_n, memw_n, ior_n_o, iow_n_o};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_xfer(input logic [15:0] a, input logic [1:0] k, input bit t, input bit m, input int waits);
        bit need_hi = !hv || (a[15:8] != last_hi);
        string hreq = (!hv && a[15:8] == last_hi) ? "R11" : "R2";
        logic [3:0] es = exp_strb(k);
        @(negedge clk);
        start = 1; xfer_addr = a; xfer_kind = k; xfer_tc = t; xfer_mark = m;
        ready = (waits == 0);
        @(negedge clk);
        start = 0; xfer_addr = $urandom; xfer_kind = 2'($urandom); xfer_tc = 1'($urandom); xfer_mark = 1'($urandom);
        if (need_hi) begin
            chk(adstb === 1 && data_oe === 1 && data_o === a[15:8] && pins() === 4'hf,
                hreq, {adstb, data_oe, data_o, pins()}, {2'b11, a[15:8], 4'hf});
            chk(aen === 1 && addr_lo_oe === 1 && addr_lo_o === a[7:0], "R4", {aen, addr_lo_o}, {1'b1, a[7:0]});
            @(negedge clk);
        end
        chk(adstb === 0 && data_oe === 0, need_hi ? "R2" : "R3", {adstb, data_oe}, 2'b00);
        chk(pins() === es, kind_req(k), pins(), es);
        chk(aen === 1 && addr_lo_oe === 1 && addr_lo_o === a[7:0], "R4", {aen, addr_lo_oe, addr_lo_o}, {2'b11, a[7:0]});
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            chk(pins() === es && done === 0 && busy === 1, "R8", {done, pins()}, {1'b0, es});
            ready = (i == waits);
        end
        @(negedge clk);
        chk(pins() === 4'hf && done === 1 && tc_o === t && mark_o === m, "R9",
            {done, tc_o, mark_o, pins()}, {1'b1, t, m, 4'hf});
        @(negedge clk);
        chk(busy === 0 && done === 0 && tc_o === 0 && mark_o === 0 && aen === 0, "R9",
            {busy, done, tc_o, mark_o, aen}, 5'b0);
        hv = 1; last_hi = a[15:8]; ready = 1;
    endtask

    task automatic leave_master(input int n);
        @(negedge clk); master = 0;
        repeat (n) @(negedge clk);
        chk(addr_lo_oe === 0 && data_oe === 0 && io_oe === 0 && aen === 0, "R10",
            {addr_lo_oe, data_oe, io_oe, aen}, 4'b0);
        master = 1; hv = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; master = 1; start = 0; xfer_addr = 16'h1234; xfer_kind = 2'b10;
        xfer_tc = 0; xfer_mark = 0; ready = 1; addr_lo_i = 0; cs_n = 1; ior_n_i = 1; iow_n_i = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 0 && done === 0 && adstb === 0 && aen === 0 && data_oe === 0 && tc_o === 0 && mark_o === 0,
            "R1", {busy, done, adstb, aen, data_oe, tc_o, mark_o}, 7'b0);
        chk(pins() === 4'hf, "R1", pins(), 4'hf);
        rst_n = 1;

        // Directed: first transfer, repeat high byte, each kind, long stall.
        do_xfer(16'hA55A, 2'b10, 1, 0, 0);
        do_xfer(16'hA501, 2'b01, 0, 1, 0);
        do_xfer(16'hA5FF, 2'b00, 1, 1, 4);
        do_xfer(16'hA500, 2'b11, 0, 0, 1);
        do_xfer(16'h3C00, 2'b10, 0, 0, 6);

        // Directed: exit and re-enter master with unchanged high byte.
        leave_master(1);
        do_xfer(16'h3C10, 2'b01, 0, 0, 0);

        // Slave mode: host access decode and ignored start.
        @(negedge clk); master = 0; hv = 0;
        for (int i = 0; i < 8; i++) begin
            addr_lo_i = 4'($urandom); cs_n = 1'($urandom); ior_n_i = 1'($urandom); iow_n_i = 1'($urandom);
            start = 1'($urandom);
            #1;
            chk(reg_sel === addr_lo_i && reg_rd === (!cs_n && !ior_n_i) && reg_wr === (!cs_n && !iow_n_i),
                "R10", {reg_sel, reg_rd, reg_wr}, {addr_lo_i, !cs_n && !ior_n_i, !cs_n && !iow_n_i});
            @(negedge clk);
            chk(busy === 0 && pins() === 4'hf && io_oe === 0 && addr_lo_oe === 0, "R10",
                {busy, io_oe, addr_lo_oe, pins()}, {3'b0, 4'hf});
        end
        start = 0; cs_n = 1; ior_n_i = 1; iow_n_i = 1; master = 1;
        @(negedge clk);
        chk(reg_rd === 0 && reg_wr === 0, "R10", {reg_rd, reg_wr}, 2'b0);

        // Random transfers; high byte from two values to mix repeats and changes.
        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            a = {($urandom_range(0, 1) != 0) ? 8'h42 : 8'hC7, 8'($urandom)};
            do_xfer(a, 2'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) leave_master($urandom_range(1, 3));
        end
        finish_run();
    end
endmodule